// File: doc/BRIEF.md
# SD Host Command-Path Engine

This block drives the command line of an SD or MMC host. A register write supplies a 6-bit command index, a 32-bit argument and a 16-bit control word. The engine builds the 48-bit command frame with its CRC7 and shifts it out most significant bit first, one bit per SD clock enable. It then releases the line and listens for the card's reply. The reply's length and checks are chosen by an explicit response-type field, never guessed from the index.

A received reply is stored with its CRC and end bit removed and can be read back as four 32-bit words. Four sticky error flags report a missing reply, a bad CRC, a bad end bit and a wrong echoed index. A one-cycle done pulse marks the end of every command, with or without an error. For replies that carry a busy phase, the engine keeps its busy flag up until the card releases DAT0.

The controller runs in six states. ST_IDLE goes to ST_SEND when a command is written. ST_SEND goes to ST_DONE after the 48th bit if no reply is expected, and to ST_WAIT otherwise. ST_WAIT goes to ST_RECV when a start bit arrives, or to ST_DONE when the wait runs out. ST_RECV goes to ST_BUSY after the last bit of a busy-type reply, and to ST_DONE otherwise. ST_BUSY goes to ST_DONE when DAT0 is sampled high. ST_DONE always returns to ST_IDLE.

Top module: `sdc_cmd_engine`

## Requirements
- R1: When `cmd_wr` is high while `busy` is low, the engine latches index, argument and control word. `busy` is high in the next cycle, and all four error flags read 0 in that cycle.
- R2: The command goes out on `cmd_out` as 48 bits, most significant bit first, one bit per `sd_tick`: 0, 1, the index, the argument, then a CRC7. The CRC uses polynomial x^7+x^3+1, starts from zero and covers the first 40 bits. A 1 ends the frame. `cmd_oe` is high for exactly those 48 ticks, and `cmd_out` is 1 whenever `cmd_oe` is low.
- R3: Control bits 10:8 pick the reply type: 3 none, 4 short with CRC and index checks, 5 short with checks plus busy, 6 long (136 bits) without checks, 7 short without checks. Codes 0, 1 and 2 act as "none". All other control bits have no effect on the line or the result.
- R4: With no reply expected, `rsp_done` pulses in the cycle right after the tick that sends the 48th bit.
- R5: The start bit (0) of a reply must appear on one of the first 64 ticks after the frame. Otherwise `err_timeout` is set and `rsp_done` follows the 64th tick. On a timeout, no other error flag is set.
- R6: After a short reply, word 0 (`rsp_sel`=0) holds received bits 39:8, counting the end bit as bit 0. Words 1 to 3 read 0.
- R7: After a long reply, words 0, 1, 2 and 3 hold received bits 39:8, 71:40, 103:72 and 127:104, with word 3 zero-extended from 24 bits.
- R8: For types 4 and 5, `err_crc` is set when the CRC7 of received bits 47:8 differs from received bits 7:1.
- R9: For every reply type, `err_end` is set when the last received bit is 0.
- R10: For types 4 and 5, `err_index` is set when received bits 45:40 differ from the sent index. Types 6 and 7 never set `err_index` or `err_crc`.
- R11: For type 5, after the reply's last bit the engine keeps sampling `dat0_in` on each tick. `rsp_done` follows the first tick on which `dat0_in` is 1.
- R12: `cmd_wr` while `busy` is high is ignored. The frame in flight, the index check and the stored reply keep the first command's values.
- R13: `rsp_done` is high for one cycle when a command ends, and `busy` is low in the cycle after. The error flags hold their values until the next accepted command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sd_tick | input | 1 | SD clock enable, one pulse per line bit |
| cmd_wr | input | 1 | Command write strobe |
| cmd_index | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| cmd_ctl | input | 16 | Control word; bits 10:8 reply type |
| cmd_in | input | 1 | CMD line input from the card |
| dat0_in | input | 1 | DAT0 line input, low while the card is busy |
| rsp_sel | input | 2 | Reply word select |
| cmd_out | output | 1 | CMD line output value |
| cmd_oe | output | 1 | CMD line drive enable |
| busy | output | 1 | Command in progress |
| rsp_done | output | 1 | One-cycle end-of-command pulse |
| err_timeout | output | 1 | No reply start bit in time |
| err_crc | output | 1 | Reply CRC7 mismatch |
| err_end | output | 1 | Reply end bit was 0 |
| err_index | output | 1 | Echoed index mismatch |
| rsp_rdata | output | 32 | Selected reply word |

## Verification
The bound checker watches several rules on every cycle. The line may be driven only while busy, and it idles high. An accepted write raises busy with the error flags clear. The done pulse lasts one cycle and drops busy. Error flags stay put while idle, and a timeout never comes with another error. The exact bit sequence and CRC of each frame, the tick count up to done for each reply type, delay and DAT0 busy length, the packing of the reply words, and which errors each kind of corrupted reply raises can only be shown by the bench. It sweeps these against frames and counts it computes itself.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
    localparam int CMD_BITS   = 48;
    localparam int SHORT_BITS = 48;
    localparam int LONG_BITS  = 136;
    localparam int CRC_SPAN   = 40;
    localparam int CRC_W      = 7;
    localparam int IDX_W      = 6;
    localparam int ARG_W      = 32;
    localparam int CTL_W      = 16;
    localparam int STRIP_BITS = 8;
    localparam int WORD_W     = 32;
    localparam int RSP_WORDS  = 4;
    localparam int SEL_W      = $clog2(RSP_WORDS);
    localparam int CNT_W      = $clog2(LONG_BITS + 1);
    localparam int RT_LO      = 8;
    localparam int RT_W       = 3;

    typedef enum logic [2:0] {
        ST_IDLE, ST_SEND, ST_WAIT, ST_RECV, ST_BUSY, ST_DONE
    } sdc_state_e;

    typedef enum logic [1:0] {RK_NONE, RK_SHORT, RK_LONG} rsp_kind_e;

    typedef struct packed {
        rsp_kind_e kind;
        logic      chk_crc;
        logic      chk_idx;
        logic      wait_dat0;
    } rsp_cfg_t;

    function automatic rsp_cfg_t decode_rtype(input logic [RT_W-1:0] code);
        rsp_cfg_t c;
        c = '{kind: RK_NONE, chk_crc: 1'b0, chk_idx: 1'b0, wait_dat0: 1'b0};
        case (code)
            3'd4: c = '{kind: RK_SHORT, chk_crc: 1'b1, chk_idx: 1'b1, wait_dat0: 1'b0};
            3'd5: c = '{kind: RK_SHORT, chk_crc: 1'b1, chk_idx: 1'b1, wait_dat0: 1'b1};
            3'd6: c = '{kind: RK_LONG,  chk_crc: 1'b0, chk_idx: 1'b0, wait_dat0: 1'b0};
            3'd7: c = '{kind: RK_SHORT, chk_crc: 1'b0, chk_idx: 1'b0, wait_dat0: 1'b0};
            default: ;
        endcase
        return c;
    endfunction
endpackage

// File: rtl/sdc_crc7.sv
module sdc_crc7 #(
    parameter int N = 40
) (
    input  logic [N-1:0] bits_i,
    output logic [6:0]   crc_o
);
    always_comb begin
        logic fb;
        crc_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            fb    = bits_i[i] ^ crc_o[6];
            crc_o = {crc_o[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
        end
    end
endmodule

// File: rtl/sdc_rsp_store.sv
module sdc_rsp_store
    import sdc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 store_i,
    input  logic                 long_i,
    input  logic [LONG_BITS-1:0] frame_i,
    input  logic [SEL_W-1:0]     sel_i,
    output logic [WORD_W-1:0]    rdata_o
);
    localparam int TOP_BIT = LONG_BITS - STRIP_BITS - 1;

    logic [WORD_W-1:0] words [RSP_WORDS];

    for (genvar w = 0; w < RSP_WORDS; w++) begin : g_word
        localparam int LO = STRIP_BITS + WORD_W * w;
        localparam int HI = (LO + WORD_W - 1 > TOP_BIT) ? TOP_BIT : LO + WORD_W - 1;
        logic [WORD_W-1:0] q;
        logic keep;
        assign keep = long_i || (w == 0);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= '0;
            end else if (store_i) begin
                q <= keep ? WORD_W'(frame_i[HI:LO]) : '0;
            end
        end
        assign words[w] = q;
    end

    assign rdata_o = words[sel_i];
endmodule

// File: rtl/sdc_cmd_engine.sv
module sdc_cmd_engine
    import sdc_pkg::*;
#(
    parameter int TIMEOUT_TICKS = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sd_tick,
    input  logic              cmd_wr,
    input  logic [IDX_W-1:0]  cmd_index,
    input  logic [ARG_W-1:0]  cmd_arg,
    input  logic [CTL_W-1:0]  cmd_ctl,
    input  logic              cmd_in,
    input  logic              dat0_in,
    input  logic [SEL_W-1:0]  rsp_sel,
    output logic              cmd_out,
    output logic              cmd_oe,
    output logic              busy,
    output logic              rsp_done,
    output logic              err_timeout,
    output logic              err_crc,
    output logic              err_end,
    output logic              err_index,
    output logic [WORD_W-1:0] rsp_rdata
);
    localparam int TMO_W  = $clog2(TIMEOUT_TICKS + 1);
    localparam int IDX_HI = SHORT_BITS - 3;
    localparam int IDX_LO = IDX_HI - IDX_W + 1;
    localparam logic [CNT_W-1:0] TX_LAST    = CNT_W'(CMD_BITS - 1);
    localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_BITS - 1);
    localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_BITS - 1);
    localparam logic [TMO_W-1:0] TMO_LAST   = TMO_W'(TIMEOUT_TICKS - 1);

    sdc_state_e           state_q, state_d;
    logic [CNT_W-1:0]     cnt_q;
    logic [TMO_W-1:0]     tmo_q;
    logic [CMD_BITS-1:0]  tx_sr_q;
    logic [LONG_BITS-1:0] rx_sr_q;
    logic [LONG_BITS-1:0] rx_sr_nxt;
    logic [IDX_W-1:0]     idx_q;
    rsp_cfg_t             cfg_q;
    logic [CRC_W-1:0]     tx_crc, rx_crc;
    logic                 accept, tx_last, rx_last, tmo_last, store;
    logic                 e_tmo_q, e_crc_q, e_end_q, e_idx_q;
    logic                 ctl_unused;

    assign ctl_unused = ^{cmd_ctl[CTL_W-1:RT_LO+RT_W], cmd_ctl[RT_LO-1:0], rx_sr_q[LONG_BITS-1]};

    assign accept    = (state_q == ST_IDLE) && cmd_wr;
    assign tx_last   = (cnt_q == TX_LAST);
    assign rx_last   = (cnt_q == ((cfg_q.kind == RK_LONG) ? LONG_LAST : SHORT_LAST));
    assign tmo_last  = (tmo_q == TMO_LAST);
    assign rx_sr_nxt = {rx_sr_q[LONG_BITS-2:0], cmd_in};
    assign store     = (state_q == ST_RECV) && sd_tick && rx_last;

    sdc_crc7 #(.N(CRC_SPAN)) u_tx_crc (
        .bits_i ({2'b01, cmd_index, cmd_arg}),
        .crc_o  (tx_crc)
    );

    sdc_crc7 #(.N(CRC_SPAN)) u_rx_crc (
        .bits_i (rx_sr_nxt[SHORT_BITS-1:SHORT_BITS-CRC_SPAN]),
        .crc_o  (rx_crc)
    );

    sdc_rsp_store u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .store_i (store),
        .long_i  (cfg_q.kind == RK_LONG),
        .frame_i (rx_sr_nxt),
        .sel_i   (rsp_sel),
        .rdata_o (rsp_rdata)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (cmd_wr) state_d = ST_SEND;
            ST_SEND: if (sd_tick && tx_last)
                         state_d = (cfg_q.kind == RK_NONE) ? ST_DONE : ST_WAIT;
            ST_WAIT: if (sd_tick) begin
                         if (!cmd_in)      state_d = ST_RECV;
                         else if (tmo_last) state_d = ST_DONE;
                     end
            ST_RECV: if (sd_tick && rx_last)
                         state_d = cfg_q.wait_dat0 ? ST_BUSY : ST_DONE;
            ST_BUSY: if (sd_tick && dat0_in) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            tmo_q   <= '0;
            tx_sr_q <= '1;
            rx_sr_q <= '0;
            idx_q   <= '0;
            cfg_q   <= '{kind: RK_NONE, chk_crc: 1'b0, chk_idx: 1'b0, wait_dat0: 1'b0};
            e_tmo_q <= 1'b0;
            e_crc_q <= 1'b0;
            e_end_q <= 1'b0;
            e_idx_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (accept) begin
                    idx_q   <= cmd_index;
                    cfg_q   <= decode_rtype(cmd_ctl[RT_LO+RT_W-1:RT_LO]);
                    tx_sr_q <= {2'b01, cmd_index, cmd_arg, tx_crc, 1'b1};
                    cnt_q   <= '0;
                    e_tmo_q <= 1'b0;
                    e_crc_q <= 1'b0;
                    e_end_q <= 1'b0;
                    e_idx_q <= 1'b0;
                end
                ST_SEND: if (sd_tick) begin
                    tx_sr_q <= {tx_sr_q[CMD_BITS-2:0], 1'b1};
                    cnt_q   <= tx_last ? '0 : cnt_q + 1'b1;
                    tmo_q   <= '0;
                end
                ST_WAIT: if (sd_tick) begin
                    if (!cmd_in) begin
                        cnt_q   <= CNT_W'(1);
                        rx_sr_q <= '0;
                    end else begin
                        tmo_q <= tmo_q + 1'b1;
                        if (tmo_last) e_tmo_q <= 1'b1;
                    end
                end
                ST_RECV: if (sd_tick) begin
                    rx_sr_q <= rx_sr_nxt;
                    cnt_q   <= cnt_q + 1'b1;
                    if (rx_last) begin
                        e_end_q <= ~cmd_in;
                        e_crc_q <= cfg_q.chk_crc && (rx_crc != rx_sr_nxt[CRC_W:1]);
                        e_idx_q <= cfg_q.chk_idx && (rx_sr_nxt[IDX_HI:IDX_LO] != idx_q);
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        cmd_oe      = (state_q == ST_SEND);
        cmd_out     = (state_q == ST_SEND) ? tx_sr_q[CMD_BITS-1] : 1'b1;
        busy        = (state_q != ST_IDLE);
        rsp_done    = (state_q == ST_DONE);
        err_timeout = e_tmo_q;
        err_crc     = e_crc_q;
        err_end     = e_end_q;
        err_index   = e_idx_q;
    end
endmodule

// File: rtl/sdc_cmd_engine_chk.sv
module sdc_cmd_engine_chk (
    input logic clk,
    input logic rst_n,
    input logic cmd_wr,
    input logic cmd_out,
    input logic cmd_oe,
    input logic busy,
    input logic rsp_done,
    input logic err_timeout,
    input logic err_crc,
    input logic err_end,
    input logic err_index
);
    AST_OE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_oe |-> busy); // R2
    AST_LINE_IDLES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_oe |-> cmd_out); // R2
    AST_ACCEPT_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !busy) |=> busy); // R1
    AST_ACCEPT_CLEARS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !busy) |=> !(err_timeout || err_crc || err_end || err_index)); // R1
    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !rsp_done) |=> busy); // R12
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done); // R13
    AST_DONE_DROPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !busy); // R13
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !cmd_wr) |=> $stable({err_timeout, err_crc, err_end, err_index})); // R13
    AST_TIMEOUT_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
        err_timeout |-> !(err_crc || err_end || err_index)); // R5
endmodule

bind sdc_cmd_engine sdc_cmd_engine_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_wr      (cmd_wr),
    .cmd_out     (cmd_out),
    .cmd_oe      (cmd_oe),
    .busy        (busy),
    .rsp_done    (rsp_done),
    .err_timeout (err_timeout),
    .err_crc     (err_crc),
    .err_end     (err_end),
    .err_index   (err_index)
);

// File: tb/sdc_cmd_engine_tb.sv
module sdc_cmd_engine_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sd_tick = 1'b0;
    logic        cmd_wr = 1'b0;
    logic [5:0]  cmd_index = '0;
    logic [31:0] cmd_arg = '0;
    logic [15:0] cmd_ctl = '0;
    logic        cmd_in = 1'b1;
    logic        dat0_in = 1'b1;
    logic [1:0]  rsp_sel = '0;
    logic        cmd_out, cmd_oe, busy, rsp_done;
    logic        err_timeout, err_crc, err_end, err_index;
    logic [31:0] rsp_rdata;

    int n_checks = 0;
    int n_fail = 0;
    int done_cnt = 0;

    always #4 clk = ~clk;

    sdc_cmd_engine u_dut (
        .clk(clk), .rst_n(rst_n), .sd_tick(sd_tick), .cmd_wr(cmd_wr),
        .cmd_index(cmd_index), .cmd_arg(cmd_arg), .cmd_ctl(cmd_ctl),
        .cmd_in(cmd_in), .dat0_in(dat0_in), .rsp_sel(rsp_sel),
        .cmd_out(cmd_out), .cmd_oe(cmd_oe), .busy(busy), .rsp_done(rsp_done),
        .err_timeout(err_timeout), .err_crc(err_crc), .err_end(err_end),
        .err_index(err_index), .rsp_rdata(rsp_rdata)
    );

    always @(negedge clk) if (rsp_done) done_cnt <= done_cnt + 1;

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish (actual=hung expected=finished)");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks + 1, n_fail);
        $finish;
    end

    task automatic chk(input string req, input string what, input logic [135:0] act,
                       input logic [135:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [6:0] ref_crc7(input logic [39:0] v);
        logic [6:0] r = '0;
        for (int i = 39; i >= 0; i--) begin
            logic top = r[6] ^ v[i];
            r = r << 1;
            if (top) r = r ^ 7'b0001001;
        end
        return r;
    endfunction

    function automatic logic [135:0] short_rsp(input logic [5:0] idx, input logic [31:0] pl,
                                               input bit bad_crc, input bit bad_end,
                                               input bit bad_idx);
        logic [39:0] head = {2'b00, idx ^ (bad_idx ? 6'h01 : 6'h00), pl};
        logic [6:0]  c = ref_crc7(head) ^ (bad_crc ? 7'h01 : 7'h00);
        return 136'({head, c, ~bad_end});
    endfunction

    function automatic logic [135:0] long_rsp(input logic [5:0] idx, input logic [31:0] a,
                                              input bit bad_end);
        logic [127:0] p = {a, ~a, a ^ 32'hA5A5_5A5A, idx, 2'b10, 24'hC33C96};
        return {2'b00, 6'h3F, p[127:1], ~bad_end};
    endfunction

    task automatic do_tick(input logic cin, input logic d0, output logic o, output logic oe);
        sd_tick = 1'b1; cmd_in = cin; dat0_in = d0;
        #1; o = cmd_out; oe = cmd_oe;
        @(posedge clk); @(negedge clk);
        sd_tick = 1'b0;
        @(negedge clk); @(negedge clk);
    endtask

    task automatic exec(input logic [5:0] idx, input logic [31:0] arg, input logic [15:0] ctl,
                        input logic [135:0] rsp, input int rlen, input int d, input int k,
                        input bit inject, output int t);
        logic [47:0] got = '0;
        logic [47:0] expf = {2'b01, idx, arg, ref_crc7({2'b01, idx, arg}), 1'b1};
        int oe_cnt = 0;
        int base = done_cnt;
        logic o, oe;
        cmd_wr = 1'b1; cmd_index = idx; cmd_arg = arg; cmd_ctl = ctl;
        @(negedge clk);
        cmd_wr = 1'b0;
        chk("R1", "busy after accept", 136'(busy), 136'(1));
        chk("R1", "errors cleared at accept",
            136'({err_timeout, err_crc, err_end, err_index}), 136'(0));
        for (int b = 0; b < 48; b++) begin
            if (inject && b == 10) begin
                cmd_wr = 1'b1; cmd_index = ~idx; cmd_arg = ~arg; cmd_ctl = 16'h0300;
            end
            do_tick(1'b1, 1'b1, o, oe);
            cmd_wr = 1'b0;
            got = {got[46:0], o};
            if (oe) oe_cnt++;
        end
        chk(inject ? "R12" : "R2", "command frame", 136'(got), 136'(expf));
        chk("R2", "drive enable ticks", 136'(oe_cnt), 136'(48));
        t = 0;
        while (done_cnt == base && t < 400) begin
            logic cin = 1'b1;
            logic d0 = 1'b1;
            if (t >= d && t - d < rlen) cin = rsp[rlen - 1 - (t - d)];
            if (t >= d + rlen && t < d + rlen + k) d0 = 1'b0;
            do_tick(cin, d0, o, oe);
            t++;
        end
        chk("R13", "busy low after done", 136'(busy), 136'(0));
    endtask

    task automatic chk_errs(input string req, input logic [3:0] exp);
        chk(req, "error flags {tmo,crc,end,idx}",
            136'({err_timeout, err_crc, err_end, err_index}), 136'(exp));
    endtask

    task automatic chk_words(input string req, input logic [135:0] f, input bit lng);
        logic [31:0] e [4];
        e[0] = f[39:8];
        e[1] = lng ? f[71:40] : 32'h0;
        e[2] = lng ? f[103:72] : 32'h0;
        e[3] = lng ? {8'h00, f[127:104]} : 32'h0;
        for (int w = 0; w < 4; w++) begin
            rsp_sel = 2'(w);
            #1;
            chk(req, $sformatf("reply word %0d", w), 136'(rsp_rdata), 136'(e[w]));
        end
    endtask

    initial begin
        int t;
        logic [135:0] f;
        logic [5:0] idx;
        logic [31:0] arg;
        repeat (5) @(negedge clk);
        chk("R13", "reset busy/done", 136'({busy, rsp_done}), 136'(0));
        chk("R2", "reset line {oe,out}", 136'({cmd_oe, cmd_out}), 136'(2'b01));
        chk("R1", "reset errors", 136'({err_timeout, err_crc, err_end, err_index}), 136'(0));
        rst_n = 1'b1;
        @(negedge clk);

        // R3 R4: codes with no reply
        for (int code = 0; code < 4; code++) begin
            idx = 6'(code * 13 + 2);
            arg = 32'h1357_9BDF * (code + 1);
            exec(idx, arg, 16'(code << 8), '0, 48, 0, 0, 0, t);
            chk("R4", $sformatf("no-reply ticks code %0d", code), 136'(t), 136'(0));
            chk_errs("R3", 4'b0000);
        end

        // R6: short replies, delay sweep, index sweep
        for (int i = 0; i < 4; i++) begin
            int d = (i == 3) ? 63 : i * 7;
            idx = 6'(i * 17 + 1);
            arg = 32'hDEAD_0000 + 32'(i * 32'h1111);
            f = short_rsp(idx, arg ^ 32'h0F0F_F0F0, 0, 0, 0);
            exec(idx, arg, 16'h0400, f, 48, d, 0, 0, t);
            chk("R6", $sformatf("short ticks delay %0d", d), 136'(t), 136'(d + 48));
            chk_errs("R8", 4'b0000);
            chk_words("R6", f, 0);
        end

        // R11: busy-type reply, DAT0 low for k ticks
        for (int k = 0; k < 4; k += 3) begin
            idx = 6'd7; arg = 32'h0000_1200 + 32'(k);
            f = short_rsp(idx, 32'h0000_0900, 0, 0, 0);
            exec(idx, arg, 16'h0500, f, 48, 2, k, 0, t);
            chk("R11", $sformatf("busy ticks k=%0d", k), 136'(t), 136'(2 + 48 + k + 1));
            chk_errs("R11", 4'b0000);
        end

        // R7: long reply
        idx = 6'd2; arg = 32'h89AB_CDEF;
        f = long_rsp(idx, 32'h1234_5678, 0);
        exec(idx, arg, 16'h0600, f, 136, 3, 0, 0, t);
        chk("R7", "long ticks", 136'(t), 136'(3 + 136));
        chk_errs("R7", 4'b0000);
        chk_words("R7", f, 1);

        // R10: type 7 skips CRC and index checks
        idx = 6'd41; arg = 32'h00FF_8000;
        f = short_rsp(6'h3F, 32'h80FF_8000, 1, 0, 1);
        exec(idx, arg, 16'h0700, f, 48, 1, 0, 0, t);
        chk_errs("R10", 4'b0000);
        chk_words("R6", f, 0);

        // R8: CRC errors on checked types
        idx = 6'd17; arg = 32'h0000_0200;
        exec(idx, arg, 16'h0400, short_rsp(idx, 32'h900, 1, 0, 0), 48, 0, 0, 0, t);
        chk_errs("R8", 4'b0100);
        exec(idx, arg, 16'h0500, short_rsp(idx, 32'h900, 1, 0, 0), 48, 0, 0, 0, t);
        chk_errs("R8", 4'b0100);

        // R13: flags hold while idle
        repeat (10) @(negedge clk);
        chk_errs("R13", 4'b0100);

        // R10: index mismatch
        exec(idx, arg, 16'h0400, short_rsp(idx, 32'h900, 0, 0, 1), 48, 4, 0, 0, t);
        chk_errs("R10", 4'b0001);

        // R9: end bit errors, short and long
        exec(idx, arg, 16'h0400, short_rsp(idx, 32'h900, 0, 1, 0), 48, 0, 0, 0, t);
        chk_errs("R9", 4'b0010);
        exec(idx, arg, 16'h0600, long_rsp(idx, 32'hCAFE_F00D, 1), 136, 0, 0, 0, t);
        chk_errs("R9", 4'b0010);

        // R5: timeout
        f = short_rsp(idx, 32'h900, 0, 0, 0);
        exec(idx, arg, 16'h0400, f, 48, 64, 0, 0, t);
        chk("R5", "timeout ticks", 136'(t), 136'(64));
        chk_errs("R5", 4'b1000);

        // R12 R3: write while busy ignored, extra control bits harmless
        idx = 6'd55; arg = 32'hA0B1_C2D3;
        f = short_rsp(idx, 32'h0000_0B00, 0, 0, 0);
        exec(idx, arg, 16'h7C40 | 16'h0400, f, 48, 5, 0, 1, t);
        chk("R12", "ticks with ignored write", 136'(t), 136'(5 + 48));
        chk_errs("R12", 4'b0000);
        chk_words("R3", f, 0);

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule